// File: doc/BRIEF.md
# Dual-Bank Programmable Delay Line with Accept Buffer

This block delays a data stream by a programmable number of clocks, from 0 to 31. Every input word first lands in a staging register. When the delay is non-zero, the word is then written into one of two 16-word banks. The banks take writes in turn, and in any cycle the bank being read is never the bank being written. Each bank therefore needs only a single address bus, and one 4-bit slot address serves both banks over two consecutive writes.

Run control is a three-state machine:

- **ST_IDLE**: the run input is low. The down-counter and the held delay are reloaded from the delay input.
- **ST_FILL**: the run input is high and the programmed delay has not yet elapsed.
- **ST_FLOW**: the down-counter has reached zero. The output carries delayed data.

The transitions are:

- **go**: ST_IDLE to ST_FILL or ST_FLOW, on the first clock edge with run high.
- **drained**: ST_FILL to ST_FLOW, when the down-counter reaches zero.
- **halt**: any state to ST_IDLE, on a clock edge with run low.

Writes are organised in groups of DELAY writes. A group phase bit flips at the end of each group, and the bank chosen for each write is the slot parity XOR the group phase. Because of this, a word read back DELAY writes later always sits in the bank that is not being written, for even delays as well as odd ones. A delay of zero bypasses the banks and sends the staging register straight to the output.

A four-entry capture buffer sits at the output. On an accept strobe it stores the current output word at a write pointer that wraps. A separate index selects which entry is driven out.

Top module: `dly_line_top`

## Requirements
- R1: After reset the machine is in ST_IDLE, `dout_valid` is 0, and all four capture entries read 0.
- R2: With delay 0, `dout_valid` rises after the first clock edge with `run` high. From then on, `dout` equals the `din` value sampled at the most recent clock edge.
- R3: For every delay D from 1 to 31, while `dout_valid` is 1, `dout` equals the `din` value sampled D clock edges before the most recent edge.
- R4: `dout_valid` is 1 exactly when `run` has been high at each of the last K edges, with K at least 1 and K at least D.
- R5: D is taken from `delay` at the go transition. Changes to `delay` while running have no effect on the output.
- R6: An edge with `run` low returns the block to ST_IDLE with `dout_valid` 0. A later run refills from scratch, following R4.
- R7: An edge with `accept` high stores the `dout` value present before that edge into the entry at the write pointer. The 2-bit pointer starts at 0, then advances by one and wraps from 3 to 0. `l2_data` shows the entry indexed by `l2_sel`.
- R8: Edges with `accept` low change neither the capture entries nor the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Run level; high streams data through the delay line |
| delay | input | 5 | Programmed delay in clocks, 0 to 31 |
| din | input | 8 | Input data word |
| dout | output | 8 | Delayed output word |
| dout_valid | output | 1 | High while `dout` carries delayed data |
| accept | input | 1 | Capture strobe for the output buffer |
| l2_sel | input | 2 | Capture buffer read index |
| l2_data | output | 8 | Capture buffer entry selected by `l2_sel` |

## Verification
Two events can coincide in one cycle: a bank read and a bank write, which always target opposite banks, and an accept capture, which can land on the cycle where the group phase flips or where the output turns valid. The bench runs every delay value from 0 to 31 with random data and raises accept at random on about a quarter of the cycles. Collisions therefore fall on group boundaries, on the first valid word and on pointer wrap. The check on each output word is judged against a history of sampled inputs. The capture entries are judged against a model that records the output observed just before each accepting edge.

// File: rtl/dly_line_pkg.sv
package dly_line_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_FLOW
    } run_st_t;

    typedef enum logic [1:0] {
        SRC_STAGE,
        SRC_BANK0,
        SRC_BANK1
    } src_t;
endpackage

// File: rtl/dly_bank.sv
module dly_bank #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dly_ctrl.sv
module dly_ctrl
    import dly_line_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int DW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] delay,
    output logic          wr_en,
    output logic          wr_bank,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output src_t          src,
    output logic          valid
);
    run_st_t       state_q, state_n;
    logic [DW-1:0] dc_q, dc_n;
    logic [DW-1:0] dly_q;
    logic [DW-1:0] wn_q, rn_q, pos_q;
    logic          grp_q;
    logic [DW-1:0] deff;
    logic [DW-1:0] lag;

    assign deff = (state_q == ST_IDLE) ? delay : dly_q;
    assign lag  = wn_q - rn_q;

    // down-counter next value
    always_comb begin
        if (!run) begin
            dc_n = delay;
        end else if (state_q == ST_IDLE) begin
            dc_n = (delay == '0) ? '0 : delay - 1'b1;
        end else begin
            dc_n = (dc_q == '0) ? '0 : dc_q - 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (run) state_n = (dc_n == '0) ? ST_FLOW : ST_FILL;
            ST_FILL: if (!run) state_n = ST_IDLE;
                     else if (dc_n == '0) state_n = ST_FLOW;
            ST_FLOW: if (!run) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dc_q    <= '0;
            dly_q   <= '0;
            wn_q    <= '0;
            rn_q    <= '0;
            pos_q   <= '0;
            grp_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            dc_q    <= dc_n;
            if (state_q == ST_IDLE) begin
                dly_q <= delay;
            end
            if (!run) begin
                wn_q  <= '0;
                rn_q  <= '0;
                pos_q <= '0;
                grp_q <= 1'b0;
            end else begin
                wn_q <= wn_q + 1'b1;
                if (pos_q == deff - 1'b1) begin
                    pos_q <= '0;
                    grp_q <= ~grp_q;
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
                if (state_q == ST_FLOW) begin
                    rn_q <= rn_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        wr_en   = run && (deff != '0);
        wr_bank = pos_q[0] ^ grp_q;
        wr_addr = wn_q[DW-1:1];
        rd_addr = rn_q[DW-1:1];
        valid   = (state_q == ST_FLOW);
        if (dly_q == '0) begin
            src = SRC_STAGE;
        end else if (wr_bank) begin
            src = SRC_BANK0;
        end else begin
            src = SRC_BANK1;
        end
    end

    a_r6_drop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> state_q == ST_IDLE);
    a_r5_delay_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_IDLE |=> $stable(dly_q));
    a_r4_flow_tc: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FLOW |-> dc_q == '0);
    a_r3_read_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLOW && dly_q != '0) |-> lag == dly_q);
endmodule

// File: rtl/dly_capture.sv
module dly_capture #(
    parameter int WIDTH   = 8,
    parameter int ENTRIES = 4,
    localparam int PW = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [WIDTH-1:0] cap_data,
    input  logic [PW-1:0]    sel,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] ent_q [ENTRIES];
    logic [PW-1:0]    wp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent_q[i] <= '0;
            end
        end else if (accept) begin
            ent_q[wp_q] <= cap_data;
            wp_q        <= wp_q + 1'b1;
        end
    end

    assign q = ent_q[sel];

    a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> wp_q == $past(wp_q) + 1'b1);
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(wp_q));
endmodule

// File: rtl/dly_line_top.sv
module dly_line_top
    import dly_line_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BANK_DEPTH = 16,
    parameter int CAP_DEPTH  = 4,
    localparam int AW  = $clog2(BANK_DEPTH),
    localparam int DW  = AW + 1,
    localparam int CPW = $clog2(CAP_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DW-1:0]     delay,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    input  logic              accept,
    input  logic [CPW-1:0]    l2_sel,
    output logic [DATA_W-1:0] l2_data
);
    logic [DATA_W-1:0] stage_q;
    logic              wr_en, wr_bank;
    logic [AW-1:0]     wr_addr, rd_addr;
    src_t              src;
    logic [DATA_W-1:0] bank_q [2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= din;
        end
    end

    dly_ctrl #(.DEPTH(BANK_DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .delay   (delay),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .src     (src),
        .valid   (dout_valid)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        dly_bank #(.WIDTH(DATA_W), .DEPTH(BANK_DEPTH)) u_bank (
            .clk   (clk),
            .we    (wr_en && (wr_bank == 1'(b))),
            .waddr (wr_addr),
            .wdata (stage_q),
            .raddr (rd_addr),
            .rdata (bank_q[b])
        );
    end

    always_comb begin
        unique case (src)
            SRC_BANK0: dout = bank_q[0];
            SRC_BANK1: dout = bank_q[1];
            default:   dout = stage_q;
        endcase
    end

    dly_capture #(.WIDTH(DATA_W), .ENTRIES(CAP_DEPTH)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .cap_data (dout),
        .sel      (l2_sel),
        .q        (l2_data)
    );
endmodule

// File: tb/tb_dly_line_top.sv
module tb_dly_line_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [4:0] delay = '0;
    logic [7:0] din = '0;
    logic       accept = 1'b0;
    logic [1:0] l2_sel = '0;
    logic [7:0] dout, l2_data;
    logic       dout_valid;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] hist [64];
    int ec = 0;
    int nrun = 0;
    bit idle_m = 1'b1;
    int md = 0;
    logic [7:0] mbuf [4];
    int mwp = 0;

    always #10 clk = ~clk;

    dly_line_top dut (
        .clk(clk), .rst_n(rst_n), .run(run), .delay(delay), .din(din),
        .dout(dout), .dout_valid(dout_valid), .accept(accept),
        .l2_sel(l2_sel), .l2_data(l2_data)
    );

    function automatic logic [7:0] exp_word(int lagv);
        return hist[(ec - 1 - lagv) & 63];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic st, input logic [4:0] dl, input logic [7:0] d,
                        input logic acc, input string dtag);
        logic [7:0] pre = dout;
        bit ev;
        run = st; delay = dl; din = d; accept = acc;
        @(posedge clk);
        hist[ec & 63] = d;
        ec++;
        if (idle_m) md = int'(dl);
        idle_m = !st;
        nrun = st ? nrun + 1 : 0;
        if (acc) begin
            mbuf[mwp] = pre;
            mwp = (mwp + 1) & 3;
        end
        @(negedge clk);
        ev = (nrun > 0) && (nrun >= md);
        chk("R4 valid", 32'(dout_valid), 32'(ev));
        if (ev && dout_valid) chk(dtag, 32'(dout), 32'(exp_word(md)));
    endtask

    task automatic check_buf(string tag);
        for (int i = 0; i < 4; i++) begin
            l2_sel = 2'(i);
            #1;
            chk(tag, 32'(l2_data), 32'(mbuf[i]));
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < 4; i++) mbuf[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", 32'(dout_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", 32'(dout_valid), 0);
        check_buf("R1 capture");
        // R2, R3, R4 every delay value, random data and accepts
        for (int dv = 0; dv < 32; dv++) begin
            string tg;
            tg = (dv == 0) ? "R2 bypass" : "R3 data";
            repeat (3) step(1'b0, 5'(dv), 8'($urandom), 1'b0, tg);
            for (int k = 0; k < dv + 24; k++)
                step(1'b1, 5'(dv), 8'($urandom), ($urandom % 4) == 0, tg);
            step(1'b0, 5'(dv), 8'($urandom), 1'b0, tg);
            chk("R6 idle", 32'(dout_valid), 0);
            check_buf("R7 capture");
        end
        // R8 no accept leaves buffer unchanged
        repeat (10) step(1'b1, 5'd3, 8'($urandom), 1'b0, "R3 data");
        step(1'b0, 5'd3, 8'h00, 1'b0, "R3 data");
        check_buf("R8 hold");
        // R5 delay changes during run are ignored
        repeat (2) step(1'b0, 5'd7, 8'($urandom), 1'b0, "R5 frozen");
        for (int k = 0; k < 40; k++)
            step(1'b1, (k < 2) ? 5'd7 : 5'($urandom), 8'($urandom), 1'b0, "R5 frozen");
        // R6 one-cycle drop then refill with even delay
        step(1'b0, 5'd6, 8'($urandom), 1'b0, "R6 refill");
        for (int k = 0; k < 30; k++)
            step(1'b1, 5'd6, 8'($urandom), 1'b1, "R6 refill");
        step(1'b0, 5'd6, 8'h00, 1'b0, "R6 refill");
        chk("R6 idle", 32'(dout_valid), 0);
        check_buf("R7 wrap");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule